// File: doc/BRIEF.md
# Multiplexed Sample Selector and Input Formatter

This block sits at the front of a receive channel, between a 17-bit parallel converter bus and a digital mixer. The bus can carry a time-multiplexed stream of up to eight channels. One clock-wide active-low enable pulse marks the first channel of each frame. A programmable slot delay picks one channel from the frame. A second register, loaded on the undelayed enable, realigns the picked word so that every slot setting gives the same output timing.

The picked word is then formatted. It may be plain 16-bit fixed point or one of three mantissa/exponent layouts. It may also be offset binary, which is turned into two's complement. The result is a 16-bit sample, a 3-bit exponent for a later shift stage, and a valid strobe. In gated operation only enabled frames produce output. In zero-stuffing operation a word comes out on every clock and the non-enabled clocks carry zero. After reset the block ignores the enable until a sync pulse arms it.

Top module: `chan_pick_formatter`

## Requirements
- R1: In gated mode (`zero_stuff`=0), `samp_vld` is high on a clock exactly when the armed enable was low two clocks earlier, so each frame yields exactly one output.
- R2: In zero-stuffing mode (`zero_stuff`=1), `samp_vld` is high on every clock from the second clock after arming. Clocks that did not follow an enable carry `samp_out`=0 and `exp_out`=0.
- R3: After reset, `samp_out`=0, `exp_out`=0 and `samp_vld`=0. `in_en_n` has no effect until the clock after the first cycle with `sync_in`=1.
- R4: With `slot_sel`=d (0 to 7), the word captured is the one on `bus_in` d clocks after the enable cycle, so d=0 takes the first channel of the frame.
- R5: The word picked in frame f is presented with `samp_vld`=1 two clocks after the enable cycle of frame f+1, whatever the slot setting.
- R6: With `offset_bin`=1, bit 15 of the formatted sample is inverted. The other bits pass unchanged.
- R7: `bus_in[16:1]` are data bits 15..0 and `bus_in[0]` is the extra low bit. With `fmt_sel`=0, `samp_out`=`bus_in[16:1]`, `bus_in[0]` is ignored and `exp_out`=0.
- R8: Float layouts use data bits D15..D0 and the extra bit X. With `fmt_sel`=1, the mantissa is D15..D3 and the exponent is {D2 OR X, D1, D0}. With `fmt_sel`=2, the mantissa is D15..D2 and the exponent is {X, D1, D0}. With `fmt_sel`=3, the mantissa is D15..D1 and the exponent is {0, D0, X}. The mantissa is left-aligned in `samp_out` with zeros below it.
- R9: `samp_out` and `exp_out` change only on clocks where `samp_vld` is high. They hold while `samp_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_in | input | 17 | Parallel sample word: data bits 15..0 on [16:1], extra low bit on [0] |
| in_en_n | input | 1 | Active-low enable, one clock wide, aligned with the first channel of a frame |
| sync_in | input | 1 | Arming pulse; the enable is ignored until it has been seen |
| zero_stuff | input | 1 | 0: gated output, 1: output every clock with zeros between samples |
| slot_sel | input | 3 | Channel slot to pick, counted in clocks after the enable |
| offset_bin | input | 1 | 1: input is offset binary |
| fmt_sel | input | 2 | 0 fixed, 1 13/3, 2 14/3, 3 15/2 mantissa/exponent layout |
| samp_out | output | 16 | Formatted two's complement sample |
| exp_out | output | 3 | Exponent paired with the sample |
| samp_vld | output | 1 | Sample valid strobe |

## Verification
The assertions check four relations on every cycle. Output stays quiet until the block is armed. In gated mode the valid strobe follows the armed enable with a two-clock lag. In zero-stuffing mode the strobe is high on every clock once armed. The sample and exponent hold whenever the strobe is low. The formatter also checks its exponent range for each layout. Only the bench scenarios can show which slot of the frame is captured, the one-frame realignment latency, the bit mapping of each float layout including the OR of the exponent bit, and the offset-binary conversion, because these depend on the data sent in earlier frames.

// File: rtl/cpf_pkg.sv
package cpf_pkg;
  localparam int unsigned RAW_W  = 17;
  localparam int unsigned SAMP_W = 16;
  localparam int unsigned EXP_W  = 3;

  typedef enum logic [1:0] {
    FMT_FIXED = 2'd0,
    FMT_M13E3 = 2'd1,
    FMT_M14E3 = 2'd2,
    FMT_M15E2 = 2'd3
  } fmt_e;
endpackage

// File: rtl/cpf_slot_delay.sv
module cpf_slot_delay #(
  parameter int unsigned SLOTS = 8,
  parameter int unsigned SEL_W = $clog2(SLOTS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [SEL_W-1:0] slot_i,
  output logic             en_dly_o
);
  // tap k holds the enable seen k clocks ago
  logic [SLOTS-1:1] tap_q, tap_d;
  logic [SLOTS-1:0] all_taps;

  always_comb begin
    tap_d[1] = en_i;
    for (int k = 2; k < SLOTS; k++) tap_d[k] = tap_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tap_q <= '0;
    else        tap_q <= tap_d;
  end

  assign all_taps = {tap_q, en_i};
  assign en_dly_o = all_taps[slot_i];
endmodule

// File: rtl/cpf_slot_capture.sv
module cpf_slot_capture #(
  parameter int unsigned W = 17
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] bus_i,
  input  logic         pick_en_i,
  input  logic         frame_en_i,
  output logic [W-1:0] hold_o
);
  logic [W-1:0] pick_q, pick_d, hold_q, hold_d;

  always_comb begin
    pick_d = pick_q;
    hold_d = hold_q;
    if (pick_en_i)  pick_d = bus_i;
    if (frame_en_i) hold_d = pick_q;  // realign on the undelayed enable
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pick_q <= '0;
      hold_q <= '0;
    end else begin
      pick_q <= pick_d;
      hold_q <= hold_d;
    end
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/cpf_word_format.sv
module cpf_word_format
  import cpf_pkg::*;
(
  input  logic [RAW_W-1:0]  raw_i,
  input  fmt_e              fmt_i,
  input  logic              obin_i,
  output logic [SAMP_W-1:0] samp_o,
  output logic [EXP_W-1:0]  exp_o
);
  logic [SAMP_W-1:0] dbits, mant;
  logic              xbit;

  always_comb begin
    dbits = raw_i[RAW_W-1:1];
    xbit  = raw_i[0];
    case (fmt_i)
      FMT_M13E3: begin
        mant  = {dbits[15:3], 3'b000};
        exp_o = {dbits[2] | xbit, dbits[1], dbits[0]};
      end
      FMT_M14E3: begin
        mant  = {dbits[15:2], 2'b00};
        exp_o = {xbit, dbits[1], dbits[0]};
      end
      FMT_M15E2: begin
        mant  = {dbits[15:1], 1'b0};
        exp_o = {1'b0, dbits[0], xbit};
      end
      default: begin
        mant  = dbits;
        exp_o = '0;
      end
    endcase
    samp_o = {mant[SAMP_W-1] ^ obin_i, mant[SAMP_W-2:0]};
  end

  always_comb begin
    a_r7_fixed_no_exp: assert (fmt_i != FMT_FIXED || exp_o == '0);
    a_r8_two_bit_exp:  assert (fmt_i != FMT_M15E2 || !exp_o[2]);
  end
endmodule

// File: rtl/chan_pick_formatter.sv
module chan_pick_formatter
  import cpf_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned SEL_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RAW_W-1:0]  bus_in,
  input  logic              in_en_n,
  input  logic              sync_in,
  input  logic              zero_stuff,
  input  logic [SEL_W-1:0]  slot_sel,
  input  logic              offset_bin,
  input  logic [1:0]        fmt_sel,
  output logic [SAMP_W-1:0] samp_out,
  output logic [EXP_W-1:0]  exp_out,
  output logic              samp_vld
);
  logic              armed_q, armed_d;
  logic              en_eff, en_dly;
  logic [RAW_W-1:0]  hold_w;
  logic              go_q, go_d, blank_q, blank_d;
  logic [SAMP_W-1:0] f_samp, samp_q, samp_d;
  logic [EXP_W-1:0]  f_exp, exp_q, exp_d;
  logic              vld_q, vld_d;

  // arming: enable ignored until the first sync
  assign armed_d = armed_q | sync_in;
  assign en_eff  = ~in_en_n & armed_q;

  cpf_slot_delay #(.SLOTS(SLOTS), .SEL_W(SEL_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .en_i(en_eff), .slot_i(slot_sel), .en_dly_o(en_dly)
  );

  cpf_slot_capture #(.W(RAW_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .bus_i(bus_in),
    .pick_en_i(en_dly), .frame_en_i(en_eff), .hold_o(hold_w)
  );

  cpf_word_format u_fmt (
    .raw_i(hold_w), .fmt_i(fmt_e'(fmt_sel)), .obin_i(offset_bin),
    .samp_o(f_samp), .exp_o(f_exp)
  );

  // enable stage, same depth as the realign register
  always_comb begin
    go_d    = zero_stuff ? armed_q : en_eff;
    blank_d = zero_stuff & ~en_eff;
  end

  // output stage, loaded only when a sample is issued
  always_comb begin
    vld_d  = go_q;
    samp_d = samp_q;
    exp_d  = exp_q;
    if (go_q) begin
      samp_d = blank_q ? '0 : f_samp;
      exp_d  = blank_q ? '0 : f_exp;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      go_q    <= 1'b0;
      blank_q <= 1'b0;
      samp_q  <= '0;
      exp_q   <= '0;
      vld_q   <= 1'b0;
    end else begin
      armed_q <= armed_d;
      go_q    <= go_d;
      blank_q <= blank_d;
      samp_q  <= samp_d;
      exp_q   <= exp_d;
      vld_q   <= vld_d;
    end
  end

  assign samp_out = samp_q;
  assign exp_out  = exp_q;
  assign samp_vld = vld_q;

  a_r3_quiet_until_armed: assert property (@(posedge clk) disable iff (!rst_n)
    !armed_q |=> !samp_vld);

  a_r1_gated_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!zero_stuff, 2) |-> (samp_vld == $past(en_eff, 2)));

  a_r2_stuff_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && zero_stuff) |=> ##1 samp_vld);

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_vld |-> ($stable(samp_out) && $stable(exp_out)));
endmodule

// File: tb/chan_pick_formatter_test.sv
`timescale 1ns/1ps
module chan_pick_formatter_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] bus_in;
  logic        in_en_n, sync_in, zero_stuff, offset_bin;
  logic [2:0]  slot_sel;
  logic [1:0]  fmt_sel;
  logic [15:0] samp_out;
  logic [2:0]  exp_out;
  logic        samp_vld;

  int nchk = 0, nerr = 0, cyc = 0, cap_n = 0, fr_n = 0;
  logic [15:0] cap_s [64];
  logic [2:0]  cap_e [64];
  int          cap_c [64];
  int          fr_cyc [16];
  bit          done = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  chan_pick_formatter uut (
    .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .in_en_n(in_en_n), .sync_in(sync_in),
    .zero_stuff(zero_stuff), .slot_sel(slot_sel), .offset_bin(offset_bin),
    .fmt_sel(fmt_sel), .samp_out(samp_out), .exp_out(exp_out), .samp_vld(samp_vld)
  );

  always @(negedge clk) begin
    if (rst_n === 1'b1 && samp_vld === 1'b1 && cap_n < 64) begin
      cap_s[cap_n] = samp_out;
      cap_e[cap_n] = exp_out;
      cap_c[cap_n] = cyc;
      cap_n = cap_n + 1;
    end
  end

  // reference formatting written from R6..R8
  function automatic logic [18:0] model(input logic [16:0] b, input logic [1:0] f, input logic ob);
    logic [15:0] s;
    logic [2:0]  e;
    case (f)
      2'd1:    begin s = {b[16:4], 3'b0}; e = {b[3] | b[0], b[2], b[1]}; end
      2'd2:    begin s = {b[16:3], 2'b0}; e = {b[0], b[2], b[1]}; end
      2'd3:    begin s = {b[16:2], 1'b0}; e = {1'b0, b[1], b[0]}; end
      default: begin s = b[16:1]; e = 3'd0; end
    endcase
    if (ob) s[15] = ~s[15];
    return {e, s};
  endfunction

  function automatic logic [16:0] frame_base(input logic [16:0] b0, input int f);
    return b0 + 17'(f * 32'h4D2B);
  endfunction

  function automatic logic [16:0] chan_val(input logic [16:0] b, input int k);
    return b ^ 17'(k * 32'h246B5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic zs, input logic [2:0] sl, input logic ob, input logic [1:0] f);
    rst_n = 1'b0; bus_in = '0; in_en_n = 1'b1; sync_in = 1'b0;
    zero_stuff = zs; slot_sel = sl; offset_bin = ob; fmt_sel = f;
    repeat (3) @(negedge clk);
    cap_n = 0; fr_n = 0;
    rst_n = 1'b1;
  endtask

  task automatic pulse_sync();
    @(negedge clk); sync_in = 1'b1;
    @(negedge clk); sync_in = 1'b0;
  endtask

  task automatic send_frames(input int n, input logic [16:0] b0);
    for (int f = 0; f < n; f++) begin
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        bus_in  = chan_val(frame_base(b0, f), k);
        in_en_n = (k != 0);
        if (k == 0 && fr_n < 16) begin fr_cyc[fr_n] = cyc; fr_n++; end
      end
    end
    @(negedge clk); in_en_n = 1'b1; bus_in = '0;
  endtask

  task automatic t_reset_arming();
    do_reset(1'b0, 3'd0, 1'b0, 2'd0);
    #1;
    chk("R3 reset sample", samp_out, 0);
    chk("R3 reset exponent", exp_out, 0);
    chk("R3 reset valid", samp_vld, 0);
    send_frames(2, 17'h13579);
    repeat (3) @(negedge clk); #1;
    chk("R3 enable ignored before sync", cap_n, 0);
    chk("R3 sample untouched before sync", samp_out, 0);
    pulse_sync();
    send_frames(2, 17'h13579);
    repeat (3) @(negedge clk); #1;
    chk("R3 enable accepted after sync", cap_n, 2);
  endtask

  task automatic t_gated(input logic [2:0] sl, input logic ob, input logic [1:0] f,
                         input logic [16:0] b0, input string ftag);
    logic [18:0] e;
    do_reset(1'b0, sl, ob, f);
    pulse_sync();
    send_frames(4, b0);
    repeat (4) @(negedge clk); #1;
    chk("R1 one output per frame", cap_n, 4);
    for (int i = 1; i < 4; i++) begin
      e = model(chan_val(frame_base(b0, i - 1), int'(sl)), f, ob);
      chk({"R4 picked slot, ", ftag, " sample"}, cap_s[i], e[15:0]);
      chk({ftag, " exponent"}, cap_e[i], e[18:16]);
      chk("R5 realigned latency", cap_c[i] - fr_cyc[i], 2);
    end
    chk("R9 sample held while idle", samp_out, cap_s[3]);
    chk("R9 exponent held while idle", exp_out, cap_e[3]);
  endtask

  task automatic t_stuff(input logic [2:0] sl, input logic [1:0] f, input logic [16:0] b0);
    int gaps = 0, nz = 0;
    logic [18:0] e;
    do_reset(1'b1, sl, 1'b0, f);
    pulse_sync();
    send_frames(3, b0);
    repeat (2) @(negedge clk); #1;
    for (int j = 1; j < cap_n; j++) if (cap_c[j] != cap_c[j-1] + 1) gaps++;
    chk("R2 valid every clock", gaps, 0);
    chk("R2 enough outputs", cap_n >= 24, 1);
    for (int j = 0; j < cap_n; j++) if (cap_s[j] != 0 || cap_e[j] != 0) nz++;
    chk("R2 zeros between samples", nz, 2);
    for (int i = 1; i < 3; i++) begin
      e = model(chan_val(frame_base(b0, i - 1), int'(sl)), f, 1'b0);
      for (int j = 0; j < cap_n; j++) begin
        if (cap_c[j] == fr_cyc[i] + 2) begin
          chk("R2 stuffed-stream sample", cap_s[j], e[15:0]);
          chk("R2 stuffed-stream exponent", cap_e[j], e[18:16]);
        end
      end
    end
  endtask

  initial begin
    t_reset_arming();
    t_gated(3'd0, 1'b0, 2'd0, 17'h0B7E5, "R7");
    t_gated(3'd3, 1'b0, 2'd0, 17'h1C0DE, "R7");
    t_gated(3'd7, 1'b0, 2'd0, 17'h05A3F, "R7");
    t_gated(3'd1, 1'b1, 2'd0, 17'h0F0F3, "R6");
    t_gated(3'd0, 1'b0, 2'd1, 17'h1A5B1, "R8");
    chk("R8 exponent top bit from extra pin", cap_e[1][2], 1);
    t_gated(3'd0, 1'b0, 2'd2, 17'h0C3F6, "R8");
    t_gated(3'd2, 1'b1, 2'd3, 17'h15A5D, "R6");
    t_stuff(3'd2, 2'd2, 17'h1F00D);
    t_stuff(3'd5, 2'd0, 17'h0ACE1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end
endmodule